// File: doc/BRIEF.md
# High-Speed Clock Loss Monitor

This block watches a fast system clock from the slow, always-running internal oscillator domain and requests a chip reset when the fast clock goes quiet while monitoring is armed. The fast clock enters only as data. It passes through a two-flop synchronizer, and its rising edges are detected on the synchronized value. Each synchronized rising edge restarts a gap counter. If the gap counter sees `LOSS_LIMIT` (default 4) consecutive oscillator cycles without an edge while monitoring is active, the block reports a loss.

Software arms the monitor by writing 1 to a sticky enable bit. Writes of 0 have no effect, and only reset clears the bit. Monitoring is held off in three cases: while the device is in its low-power halt mode, during the oscillator settling window that follows reset, and during the settling window that follows every halt release. The settling window length is counted in synchronized fast-clock rising edges, and a 3-bit selection code chooses it. If the enable bit was set before the halt, monitoring resumes by itself when the post-halt window closes.

A six-state controller sequences the block:
- `S_BOOT_SETTLE` is the window after reset.
- `S_RUN` is settled. Monitoring is active here when enabled.
- `S_HALT` is the halt mode.
- `S_WAKE_SETTLE` is the window after a halt release.
- `S_TRIP` lasts one cycle and raises the reset request.
- `S_DEAD` waits for reset.

Transitions:
- `S_BOOT_SETTLE` goes to `S_RUN` when the window is done, and to `S_HALT` on a halt.
- `S_RUN` goes to `S_HALT` on a halt, and to `S_TRIP` on a loss.
- `S_HALT` goes to `S_WAKE_SETTLE` when the halt is released.
- `S_WAKE_SETTLE` goes to `S_RUN` when the window is done, and to `S_HALT` on a halt.
- `S_TRIP` goes to `S_DEAD`.
- `S_DEAD` stays in `S_DEAD`.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset, the enable bit is 0, the selection code is 5, `mon_active` and `clk_loss_rst` are 0, and a settling window begins. `mon_active` cannot become 1 before that window has counted its edges.
- R2: A write with `en_wr`=1 and `en_wdata`=1 sets the enable bit. A write with `en_wdata`=0 is ignored, so once set the bit stays set until reset.
- R3: A settling window ends after 2^(`MIN_EXP`+c) synchronized rising edges of `hs_clk`, where c is the selection code written through `sel_wr`/`sel_wdata`. Codes 6 and 7 behave as code 5.
- R4: While `stop_mode` is 1, `mon_active` is 0, and stopping `hs_clk` produces no reset request.
- R5: After `stop_mode` falls, a new settling window runs. If the enable bit is set, `mon_active` returns to 1 on its own when the window ends, with no further write.
- R6: While monitoring is active, `LOSS_LIMIT` consecutive oscillator cycles without a synchronized rising edge of `hs_clk` cause `clk_loss_rst`, a few cycles after `hs_clk` stops.
- R7: `clk_loss_rst` is high for exactly one cycle. After it, `mon_active` stays 0 until reset, even if `hs_clk` returns.
- R8: `mon_active` equals enable AND NOT `stop_mode` AND NOT inside a settling window AND NOT tripped. With the enable bit at 0, a stopped `hs_clk` never raises a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | Internal oscillator clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_clk | input | 1 | Monitored fast clock, sampled as asynchronous data |
| stop_mode | input | 1 | 1 while the device is in halt mode |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable write data; only 1 takes effect |
| sel_wr | input | 1 | Write strobe for the settling-length code |
| sel_wdata | input | 3 | Settling-length code |
| mon_active | output | 1 | 1 while monitoring is running |
| clk_loss_rst | output | 1 | One-cycle reset request on clock loss |

## Verification
The bound assertions check several rules on every cycle:
- The enable bit never falls outside reset.
- `mon_active` is 0 during halt mode, during a settling window and while the enable bit is 0.
- Every reset request is a single cycle, and it follows a cycle in which monitoring was active.

Only the bench scenarios can show the rest:
- The window length for each selection code.
- That monitoring re-arms by itself after a halt release.
- That a stopped clock is caught within a few cycles.
- That a stopped clock is harmless during halt, during a window and while disabled.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [2:0] {
        S_BOOT_SETTLE = 3'd0,
        S_RUN         = 3'd1,
        S_HALT        = 3'd2,
        S_WAKE_SETTLE = 3'd3,
        S_TRIP        = 3'd4,
        S_DEAD        = 3'd5
    } mon_state_t;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned SEL_MAX   = 5;
    localparam int unsigned SEL_RESET = 5;

    function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] code);
        if (code > SEL_W'(SEL_MAX)) begin
            return SEL_W'(SEL_MAX);
        end
        return code;
    endfunction

endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cm_settle_timer.sv
module cm_settle_timer
    import clkmon_pkg::*;
#(
    parameter int unsigned MIN_EXP = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int unsigned CNT_W = MIN_EXP + SEL_MAX + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;
    logic [SEL_W-1:0] eff_sel;

    always_comb begin
        eff_sel = clamp_sel(sel);
        target  = CNT_W'(1) << (MIN_EXP + int'(eff_sel));
    end

    assign done = (cnt_q >= target);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (rise && !done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cm_gap_detect.sv
module cm_gap_detect #(
    parameter int unsigned LOSS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rise,
    output logic loss
);
    localparam int unsigned GW = $clog2(LOSS_LIMIT + 1);
    localparam logic [GW-1:0] LAST = GW'(LOSS_LIMIT - 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !active || rise) begin
            gap_q <= '0;
        end else if (gap_q != LAST) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assign loss = active && !rise && (gap_q == LAST);

endmodule

// File: rtl/cm_fsm.sv
module cm_fsm
    import clkmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_mode,
    input  logic       settle_done,
    input  logic       loss,
    input  logic       en,
    output logic       settling,
    output logic       active,
    output logic       rst_req
);
    mon_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_BOOT_SETTLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT_SETTLE: begin
                if (stop_mode)        state_d = S_HALT;
                else if (settle_done) state_d = S_RUN;
            end
            S_RUN: begin
                if (stop_mode) state_d = S_HALT;
                else if (loss) state_d = S_TRIP;
            end
            S_HALT: begin
                if (!stop_mode) state_d = S_WAKE_SETTLE;
            end
            S_WAKE_SETTLE: begin
                if (stop_mode)        state_d = S_HALT;
                else if (settle_done) state_d = S_RUN;
            end
            S_TRIP:  state_d = S_DEAD;
            S_DEAD:  state_d = S_DEAD;
            default: state_d = S_BOOT_SETTLE;
        endcase
    end

    always_comb begin
        settling = 1'b0;
        active   = 1'b0;
        rst_req  = 1'b0;
        unique case (state_q)
            S_BOOT_SETTLE, S_WAKE_SETTLE: settling = 1'b1;
            S_RUN:                        active   = en && !stop_mode;
            S_TRIP:                       rst_req  = 1'b1;
            S_HALT, S_DEAD:               ;
            default:                      ;
        endcase
    end

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clkmon_pkg::*;
#(
    parameter int unsigned MIN_EXP     = 11,
    parameter int unsigned LOSS_LIMIT  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_io,
    input  logic             rst_n,
    input  logic             hs_clk,
    input  logic             stop_mode,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic             mon_active,
    output logic             clk_loss_rst
);
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             rise;
    logic             settling;
    logic             settle_done;
    logic             loss;

    always_ff @(posedge clk_io) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= SEL_W'(SEL_RESET);
        end else begin
            if (en_wr && en_wdata) en_q  <= 1'b1;
            if (sel_wr)            sel_q <= sel_wdata;
        end
    end

    cm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_io),
        .rst_n    (rst_n),
        .async_in (hs_clk),
        .rise     (rise)
    );

    cm_settle_timer #(.MIN_EXP(MIN_EXP)) u_timer (
        .clk   (clk_io),
        .rst_n (rst_n),
        .run   (settling),
        .rise  (rise),
        .sel   (sel_q),
        .done  (settle_done)
    );

    cm_gap_detect #(.LOSS_LIMIT(LOSS_LIMIT)) u_gap (
        .clk    (clk_io),
        .rst_n  (rst_n),
        .active (mon_active),
        .rise   (rise),
        .loss   (loss)
    );

    cm_fsm u_fsm (
        .clk         (clk_io),
        .rst_n       (rst_n),
        .stop_mode   (stop_mode),
        .settle_done (settle_done),
        .loss        (loss),
        .en          (en_q),
        .settling    (settling),
        .active      (mon_active),
        .rst_req     (clk_loss_rst)
    );

endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk (
    input logic clk_io,
    input logic rst_n,
    input logic stop_mode,
    input logic mon_active,
    input logic clk_loss_rst,
    input logic en_q,
    input logic settling
);
    p_en_sticky_r2: assert property (@(posedge clk_io) disable iff (!rst_n)
        en_q |=> en_q);

    p_quiet_in_stop_r4: assert property (@(posedge clk_io) disable iff (!rst_n)
        stop_mode |-> !mon_active);

    p_no_active_in_window_r5: assert property (@(posedge clk_io) disable iff (!rst_n)
        settling |-> !mon_active);

    p_req_cause_r6: assert property (@(posedge clk_io) disable iff (!rst_n)
        $rose(clk_loss_rst) |-> $past(mon_active));

    p_req_single_r7: assert property (@(posedge clk_io) disable iff (!rst_n)
        clk_loss_rst |=> !clk_loss_rst && !mon_active);

    p_active_needs_en_r8: assert property (@(posedge clk_io) disable iff (!rst_n)
        mon_active |-> en_q);

endmodule

bind clk_loss_monitor clk_loss_monitor_chk u_chk (
    .clk_io       (clk_io),
    .rst_n        (rst_n),
    .stop_mode    (stop_mode),
    .mon_active   (mon_active),
    .clk_loss_rst (clk_loss_rst),
    .en_q         (en_q),
    .settling     (settling)
);

// File: tb/test_clk_loss_monitor.sv
module test_clk_loss_monitor;

    localparam int unsigned TB_MIN_EXP = 3;
    localparam int NVEC = 8;
    // stimulus: selection code; expected: edges in the settling window (R3)
    localparam int VEC_CODE  [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int VEC_EDGES [NVEC] = '{8, 16, 32, 64, 128, 256, 256, 256};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_mode = 1'b0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       mon_active;
    logic       clk_loss_rst;
    logic       hs_run = 1'b1;
    logic [1:0] hs_cnt = 2'd0;
    logic       hs_clk;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (hs_run) hs_cnt <= hs_cnt + 2'd1;
        else        hs_cnt <= 2'd0;
    end
    assign hs_clk = hs_cnt[1];

    clk_loss_monitor #(.MIN_EXP(TB_MIN_EXP)) i_clk_loss_monitor (
        .clk_io       (clk),
        .rst_n        (rst_n),
        .hs_clk       (hs_clk),
        .stop_mode    (stop_mode),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .sel_wr       (sel_wr),
        .sel_wdata    (sel_wdata),
        .mon_active   (mon_active),
        .clk_loss_rst (clk_loss_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(4);
        rst_n = 1'b1;
    endtask

    task automatic write_en(input logic v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic write_sel(input logic [2:0] v);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic wait_active(output int n, input int limit);
        n = 0;
        while (!mon_active && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_req(input int n, output int hits, output int first);
        hits = 0; first = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (clk_loss_rst) begin
                hits++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, hits, first, lo, hi;
        do_reset();
        @(negedge clk);
        check(!mon_active, "R1 reset active", int'(mon_active), 0);
        check(!clk_loss_rst, "R1 reset request", int'(clk_loss_rst), 0);

        // R1/R3: enable during boot window, default code 5 -> 256 edges
        write_en(1'b1);
        wait_active(n, 3000);
        n += 3;
        lo = 4 * 256 - 8; hi = 4 * 256 + 16;
        check(n >= lo && n <= hi, "R1 R3 boot window length", n, 4 * 256);

        // R2: write of 0 ignored
        write_en(1'b0);
        cycles(10);
        check(mon_active, "R2 zero write ignored", int'(mon_active), 1);

        // Vector table walk: R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            write_sel(3'(VEC_CODE[v]));
            @(negedge clk);
            stop_mode = 1'b1;
            cycles(2);
            check(!mon_active, "R4 inactive in stop", int'(mon_active), 0);
            hs_run = 1'b0;
            count_req(20, hits, first);
            check(hits == 0, "R4 no request in stop", hits, 0);
            hs_run = 1'b1;
            cycles(8);
            @(negedge clk);
            stop_mode = 1'b0;
            wait_active(n, 3000);
            lo = 4 * VEC_EDGES[v] - 4; hi = 4 * VEC_EDGES[v] + 14;
            check(n >= lo && n <= hi, "R3 R5 wake window length", n, 4 * VEC_EDGES[v]);
        end

        // R6/R7: clock loss while active
        cycles(10);
        check(mon_active, "R6 armed before loss", int'(mon_active), 1);
        hs_run = 1'b0;
        count_req(24, hits, first);
        check(first >= 1 && first <= 16, "R6 loss latency", first, 8);
        check(hits == 1, "R7 single-cycle request", hits, 1);
        hs_run = 1'b1;
        cycles(100);
        check(!mon_active, "R7 stays inactive after trip", int'(mon_active), 0);
        count_req(20, hits, first);
        check(hits == 0, "R7 no repeat request", hits, 0);

        // R8: enable left at 0
        do_reset();
        cycles(1200);
        check(!mon_active, "R8 disabled never active", int'(mon_active), 0);
        hs_run = 1'b0;
        count_req(30, hits, first);
        check(hits == 0, "R8 no request while disabled", hits, 0);
        hs_run = 1'b1;

        // R1: no fast clock during boot window, window never ends
        hs_run = 1'b0;
        do_reset();
        write_en(1'b1);
        count_req(300, hits, first);
        check(hits == 0, "R1 no request during window", hits, 0);
        check(!mon_active, "R1 window holds without edges", int'(mon_active), 0);
        hs_run = 1'b1;
        wait_active(n, 3000);
        check(mon_active, "R1 active after late clock", int'(mon_active), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule